// File: doc/BRIEF.md
# Prioritized Memory Command Scheduler

This block sits between a multithreaded processing pipeline and one memory port. The pipeline hands it memory reference commands. Each command carries the issuing thread's identifier, an address, a read/write flag and a priority class. The scheduler holds the commands in one queue per class. It sends them to the memory port one at a time, taking the most urgent queued command first.

When the memory answers, the scheduler does not return the result to the requester. It records a completion event, tagged with the issuing thread, in an ordered event queue. The event at the head of that queue is retired with a one-cycle wake-up pulse on the owning thread's line, so that the sleeping thread can resume. The number of classes is a parameter. Three classes suit a static-memory controller and four suit a dynamic-memory controller. The number of threads and the queue depths are also parameters.

Top module: `mem_cmd_sched`

## Requirements
- R1: After reset the block has these outputs: `mem_req_valid` is 0, `mem_rsp_ready` is 0, `wake` is all zeros and `cmd_ready` is 1 for every valid class.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low when the queue of the offered class already holds `QDEPTH` commands. A command offered while `cmd_ready` is low is dropped and is never sent to memory.
- R3: Class 0 is the most urgent, and a higher class number means lower urgency. A command of class c is never granted while any class below c has a queued command.
- R4: Commands of the same class are granted in the order in which they were taken.
- R5: At most one command is outstanding at the memory port. From the request handshake until the response is accepted, `mem_req_valid` stays low. The next request appears no earlier than the second cycle after the response is accepted.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr` and `mem_req_write` stay unchanged.
- R7: After the request handshake, `mem_rsp_ready` is high unless the event queue is full. Each accepted response enqueues one completion event carrying the thread identifier of the command.
- R8: The wake-up output is one-hot or zero. Bit t set means thread t is woken. The bit is high for exactly one cycle, in the cycle after the response is accepted, provided no other events are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The queue of the offered class has room |
| cmd_thread | input | $clog2(THREADS) | Issuing thread identifier |
| cmd_addr | input | ADDR_W | Memory address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_prio | input | $clog2(NUM_CLASSES) | Priority class, 0 most urgent |
| mem_req_valid | output | 1 | A request is presented to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_write | output | 1 | Request direction |
| mem_rsp_valid | input | 1 | Memory signals completion |
| mem_rsp_ready | output | 1 | Completion can be accepted |
| wake | output | THREADS | One-cycle wake-up pulse per thread |

## Verification
The strict-priority ordering is hard to observe from the ports. Once a command is in flight, the commands of several classes must be waiting together, and the first waiting command usually goes out at once. The bench therefore holds `mem_req_ready` low while it loads a batch. That freezes the first command at the port and lets the queues fill behind it in a random or directed order. The bench then releases the port and checks each following grant against a reference model of the per-class queues. Directed batches overfill one class, to exercise rejection, and load urgent commands after lower-class ones, to exercise overtaking.

// File: rtl/mcs_pkg.sv
// Package: shared types for the memory command scheduler.
// Assumes nothing beyond IEEE 1800-2017 enums.
package mcs_pkg;

    // Memory-port controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no command in flight, may grant
        ST_REQ  = 2'd1,   // request presented, waiting for handshake
        ST_WAIT = 2'd2    // request taken, waiting for response
    } port_state_e;

endpackage

// File: rtl/mcs_fifo.sv
// Module: mcs_fifo
// Synchronous first-in first-out store with full/empty flags.
// Assumes DEPTH is a power of two and at least 2; push when full and
// pop when empty are illegal and are excluded by the caller.
module mcs_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W:0]   wr_ptr;
    logic [PTR_W:0]   rd_ptr;

    // Write data into the slot addressed by the write pointer
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr[PTR_W-1:0]] <= din;
    end

    // Advance the pointers on push and pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Derive head data and occupancy flags
    always_comb begin
        dout  = store[rd_ptr[PTR_W-1:0]];
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mcs_prio_arb.sv
// Module: mcs_prio_arb
// Fixed-priority picker: the lowest-numbered requesting input wins.
// Assumes requests are levels (queue non-empty flags).
module mcs_prio_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_slot
            // A slot wins only if no more urgent slot requests
            assign gnt[i]    = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

endmodule

// File: rtl/mcs_port_ctrl.sv
// Module: mcs_port_ctrl
// Owns the single memory port: takes the arbitrated head command when
// idle, presents it until accepted, waits for the response and pushes a
// completion event. Assumes head_cmd is valid whenever pend is high.
module mcs_port_ctrl
    import mcs_pkg::*;
#(
    parameter int CMD_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic [CMD_W-1:0] head_cmd,
    output logic             take,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [CMD_W-1:0] cur_cmd,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic             evq_full,
    output logic             evq_push
);
    port_state_e      state_q;
    logic [CMD_W-1:0] cmd_q;

    // Decode handshakes from the current state
    always_comb begin
        take          = (state_q == ST_IDLE) && pend;
        mem_req_valid = (state_q == ST_REQ);
        mem_rsp_ready = (state_q == ST_WAIT) && !evq_full;
        evq_push      = mem_rsp_ready && mem_rsp_valid;
        cur_cmd       = cmd_q;
    end

    // Sequence one command through grant, request and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (pend) begin
                    cmd_q   <= head_cmd;
                    state_q <= ST_REQ;
                end
                ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid && !evq_full) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(cur_cmd)));
    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
    a_r5_no_req_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        evq_push |=> !mem_req_valid);
    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        evq_push |-> !evq_full);

endmodule

// File: rtl/mem_cmd_sched.sv
// Module: mem_cmd_sched (top)
// Queues commands per priority class, serves them strictly by class over
// one memory port, and retires completions through an event queue whose
// head drives a one-cycle wake-up to the issuing thread.
// Assumes THREADS is a power of two and the queue depths are powers of two.
module mem_cmd_sched #(
    parameter int NUM_CLASSES = 3,
    parameter int THREADS     = 8,
    parameter int ADDR_W      = 16,
    parameter int QDEPTH      = 4,
    parameter int EVQ_DEPTH   = 4,
    localparam int TID_W      = $clog2(THREADS),
    localparam int PRIO_W     = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [TID_W-1:0]  cmd_thread,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [PRIO_W-1:0] cmd_prio,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_write,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    output logic [THREADS-1:0] wake
);
    localparam int CMD_W = TID_W + 1 + ADDR_W;

    logic [CMD_W-1:0]       cmd_word;
    logic [CMD_W-1:0]       q_dout [NUM_CLASSES];
    logic [NUM_CLASSES-1:0] q_push;
    logic [NUM_CLASSES-1:0] q_pop;
    logic [NUM_CLASSES-1:0] q_empty;
    logic [NUM_CLASSES-1:0] q_full;
    logic [NUM_CLASSES-1:0] q_nempty;
    logic [NUM_CLASSES-1:0] q_gnt;
    logic                   any_pend;
    logic                   take;
    logic [CMD_W-1:0]       head_cmd;
    logic [CMD_W-1:0]       cur_cmd;
    logic                   evq_push;
    logic                   evq_pop;
    logic                   evq_empty;
    logic                   evq_full;
    logic [TID_W-1:0]       evq_head;

    assign cmd_word = {cmd_thread, cmd_write, cmd_addr};
    assign q_nempty = ~q_empty;

    // Report room in the queue of the offered class
    always_comb begin
        cmd_ready = 1'b0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (cmd_prio == PRIO_W'(i)) cmd_ready = !q_full[i];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CLASSES; c++) begin : g_class
            assign q_push[c] = cmd_valid && (cmd_prio == PRIO_W'(c)) && !q_full[c];
            assign q_pop[c]  = q_gnt[c] && take;

            mcs_fifo #(.WIDTH(CMD_W), .DEPTH(QDEPTH)) u_q (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (q_push[c]),
                .din   (cmd_word),
                .pop   (q_pop[c]),
                .dout  (q_dout[c]),
                .empty (q_empty[c]),
                .full  (q_full[c])
            );
        end
    endgenerate

    mcs_prio_arb #(.N(NUM_CLASSES)) u_arb (
        .req (q_nempty),
        .gnt (q_gnt),
        .any (any_pend)
    );

    // Select the head of the winning class
    always_comb begin
        head_cmd = '0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (q_gnt[i]) head_cmd = q_dout[i];
        end
    end

    mcs_port_ctrl #(.CMD_W(CMD_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend          (any_pend),
        .head_cmd      (head_cmd),
        .take          (take),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .cur_cmd       (cur_cmd),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .evq_full      (evq_full),
        .evq_push      (evq_push)
    );

    assign mem_req_addr  = cur_cmd[ADDR_W-1:0];
    assign mem_req_write = cur_cmd[ADDR_W];

    mcs_fifo #(.WIDTH(TID_W), .DEPTH(EVQ_DEPTH)) u_evq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (evq_push),
        .din   (cur_cmd[CMD_W-1 -: TID_W]),
        .pop   (evq_pop),
        .dout  (evq_head),
        .empty (evq_empty),
        .full  (evq_full)
    );

    // Retire the head event every cycle and pulse its thread
    always_comb begin
        evq_pop = !evq_empty;
        wake    = '0;
        if (evq_pop) wake[evq_head] = 1'b1;
    end

    a_r8_wake_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake));
    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_pop));
    a_r3_grant_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (|q_pop));

endmodule

// File: tb/mem_cmd_sched_tb.sv
// Bench: random and directed batches checked against a per-class queue model.
module mem_cmd_sched_tb_top;
    localparam int NC = 4;
    localparam int TH = 8;
    localparam int AW = 16;
    localparam int QD = 4;
    localparam int TW = $clog2(TH);
    localparam int PW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [TW-1:0] cmd_thread = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_write = 1'b0;
    logic [PW-1:0] cmd_prio = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_write;
    logic          mem_rsp_valid = 1'b0;
    logic          mem_rsp_ready;
    logic [TH-1:0] wake;

    always #10 clk = ~clk;

    mem_cmd_sched #(.NUM_CLASSES(NC), .THREADS(TH), .ADDR_W(AW),
                    .QDEPTH(QD), .EVQ_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_thread(cmd_thread),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_prio(cmd_prio),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .wake(wake)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [AW-1:0] t_addr [256];
    bit            t_wr   [256];
    int            t_th   [256];
    int            t_cls  [256];
    int            refq   [NC][$];
    int            next_id = 0;
    int            inflight;
    bit            have_inflight = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected next class: most urgent non-empty model queue
    function automatic int pick_class();
        for (int c = 0; c < NC; c++) if (refq[c].size() > 0) return c;
        return -1;
    endfunction

    // Offer one command at a negedge; model decides whether it is taken
    task automatic offer(input int prio);
        bit exp_ok;
        int id;
        logic [AW-1:0] a;
        id = next_id % 256;
        a  = AW'((($urandom & 32'hff) << 8) | (id & 8'hff));
        exp_ok = (refq[prio].size() < QD);
        cmd_prio   = PW'(prio);
        cmd_thread = TW'($urandom % TH);
        cmd_write  = 1'($urandom % 2);
        cmd_addr   = a;
        cmd_valid  = 1'b1;
        #1;
        chk(cmd_ready == exp_ok, "R2 cmd_ready", int'(cmd_ready), int'(exp_ok));
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_ok) begin
            t_addr[id] = a; t_wr[id] = cmd_write; t_th[id] = int'(cmd_thread);
            t_cls[id] = prio;
            next_id++;
            if (!have_inflight) begin
                inflight = id; have_inflight = 1;
                @(negedge clk);  // let the first command leave its queue
            end else begin
                refq[prio].push_back(id);
            end
        end
    endtask

    // Serve every modelled command and check order, port rules and wake-up
    task automatic drain();
        int exp, w, d, c;
        while (have_inflight) begin
            exp = inflight;
            w = 0;
            while (!mem_req_valid && w < 50) begin @(negedge clk); w++; end
            chk(mem_req_valid == 1'b1, "R3 request appears", int'(mem_req_valid), 1);
            chk(mem_req_addr == t_addr[exp], (t_cls[exp] == 0) ? "R4 grant order" : "R3 grant order",
                int'(mem_req_addr), int'(t_addr[exp]));
            chk(mem_req_write == t_wr[exp], "R4 write flag", int'(mem_req_write), int'(t_wr[exp]));
            d = $urandom % 3;
            repeat (d) @(negedge clk);
            chk(mem_req_valid && mem_req_addr == t_addr[exp], "R6 hold while not ready",
                int'(mem_req_addr), int'(t_addr[exp]));
            mem_req_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            mem_req_ready = 1'b0;
            d = $urandom % 4;
            for (int k = 0; k <= d; k++) begin
                chk(mem_req_valid == 1'b0, "R5 single outstanding", int'(mem_req_valid), 0);
                if (k < d) @(negedge clk);
            end
            mem_rsp_valid = 1'b1;
            #1;
            chk(mem_rsp_ready == 1'b1, "R7 response ready", int'(mem_rsp_ready), 1);
            @(posedge clk); @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(wake == TH'(1 << t_th[exp]), "R8 wake pulse", int'(wake), 1 << t_th[exp]);
            chk(mem_req_valid == 1'b0, "R5 no request in accept cycle", int'(mem_req_valid), 0);
            c = pick_class();
            if (c < 0) have_inflight = 0;
            else inflight = refq[c].pop_front();
            @(negedge clk);
            chk(wake == '0, "R8 one-cycle pulse", int'(wake), 0);
        end
        repeat (3) begin
            @(negedge clk);
            chk(mem_req_valid == 1'b0, "R2 rejected commands dropped", int'(mem_req_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_req_valid == 1'b0, "R1 req idle", int'(mem_req_valid), 0);
        chk(mem_rsp_ready == 1'b0, "R1 rsp idle", int'(mem_rsp_ready), 0);
        chk(wake == '0, "R1 wake idle", int'(wake), 0);
        for (int p = 0; p < NC; p++) begin
            cmd_prio = PW'(p); #1;
            chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        end
        @(negedge clk);

        // Directed: overfill the least urgent class (R2)
        for (int i = 0; i < QD + 3; i++) offer(NC - 1);
        drain();

        // Directed: urgent commands arrive after lower ones (R3, R4)
        offer(2); offer(3); offer(2); offer(1); offer(3); offer(0); offer(1); offer(0);
        drain();

        // Random batches
        for (int b = 0; b < 12; b++) begin
            int n;
            n = 4 + ($urandom % 12);
            for (int i = 0; i < n; i++) offer($urandom % NC);
            drain();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule